// File: doc/BRIEF.md
# Mixed-Latency Issue Interlock

This block sits in the decode stage of an in-order pipeline. The pipeline feeds several execution units whose latencies differ: a one-cycle integer unit, a load/store path, a pipelined adder, a pipelined multiplier and an unpipelined divider. All of these units share a single register-file write port. For the instruction currently held in decode, the block reports the unit, the destination and the two sources, and it decides whether the instruction may leave decode this cycle. It holds the instruction back when issuing it would cause one of four problems: reading a register that still has a write pending, overtaking an older write to the same register, sending a second divide into a divider that is still busy, or claiming a write-port cycle that another operation already owns.

Pending writes are kept in a reservation shift register. The entry at index k stands for the write-port cycle k cycles ahead. A single lookup at the issuing instruction's own latency finds a structural conflict, and a compare against the entries further out finds a WAW conflict. The head of the shift register drives the writeback strobe. The unit latencies count from issue to writeback: the integer and memory paths take 2 cycles (execute followed by the memory stage), the adder 5, the multiplier 8 and the divider 26.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset, wbValid is 0 and the divider is free. With idValid low, stall is 0.
- R2: The unit codes are 0 for integer, 1 for load/store, 2 for add, 3 for multiply and 4 for divide. An instruction with idDstWr=1 that issues in cycle t raises wbValid in cycle t+2 for codes 0 and 1, t+5 for code 2, t+8 for code 3 and t+26 for code 4. In that cycle wbReg equals its idDst. An instruction with idDstWr=0 produces no writeback.
- R3: A writing instruction stalls when an earlier issued operation already holds its writeback cycle.
- R4: A writing instruction stalls while an in-flight write to the same register completes later than its own writeback would.
- R5: An enabled source stalls while a write to that register is pending in a later cycle. A write completing in the current cycle does not stall, because the register file forwards it within the same cycle.
- R6: A divide stalls for 25 cycles after the previous divide issued. Other units are not affected by a busy divider.
- R7: issue equals idValid and not stall, and stall is 0 whenever no hazard of R3 to R6 applies.
- R8: At most one writeback occurs per cycle, so results leave in the order of their reserved cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idValid | input | 1 | An instruction is present in decode |
| idUnit | input | 3 | Unit code (0 int, 1 mem, 2 add, 3 mul, 4 div) |
| idDstWr | input | 1 | Instruction writes a destination register |
| idDst | input | 5 | Destination register |
| idSrcAUse | input | 1 | Source A is read |
| idSrcA | input | 5 | Source A register |
| idSrcBUse | input | 1 | Source B is read |
| idSrcB | input | 5 | Source B register |
| stall | output | 1 | Hold the instruction in decode |
| issue | output | 1 | The instruction leaves decode this cycle |
| wbValid | output | 1 | A result writes the register file this cycle |
| wbReg | output | 5 | Register written this cycle |

## Verification
Random streams draw from a small pool of registers, so RAW, WAW and write-port collisions arise often and overlap. A per-cycle model based on absolute writeback times then separates a stall caused by a source from one caused by a destination or by the port. Directed runs isolate each hazard against a hand-derived stall count: back-to-back divides give 24 stalls; a multiply followed by single-cycle operations collides on the write port once; an add that would overtake a divide to the same register waits 21 cycles; a reader of an add result waits 4. Each of these counts exposes a slot that is off by one or a compare that is missing.

// File: rtl/iil_pkg.sv
package iil_pkg;
  parameter int REG_W    = 5;
  parameter int LAT_INT  = 2;
  parameter int LAT_MEM  = 2;
  parameter int LAT_ADD  = 5;
  parameter int LAT_MUL  = 8;
  parameter int LAT_DIV  = 26;
  parameter int DIV_BUSY = 25;
  localparam int DEPTH   = LAT_DIV + 1;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DIV_BUSY + 1);

  typedef enum logic [2:0] {
    UNIT_INT = 3'd0,
    UNIT_MEM = 3'd1,
    UNIT_ADD = 3'd2,
    UNIT_MUL = 3'd3,
    UNIT_DIV = 3'd4
  } unit_e;

  typedef struct packed {
    logic             push;
    logic [IDX_W-1:0] slot;
    logic [REG_W-1:0] dst;
    logic             divStart;
  } strobe_t;
endpackage

// File: rtl/issue_dp.sv
module issue_dp
  import iil_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic [REG_W-1:0] dst,
  output logic [DEPTH-1:0] slotVld,
  output logic [DEPTH-1:0] hitA,
  output logic [DEPTH-1:0] hitB,
  output logic [DEPTH-1:0] hitD,
  output logic             divBusy,
  output logic             wbValid,
  output logic [REG_W-1:0] wbReg
);
  logic [DEPTH-1:0][REG_W-1:0] slotReg;
  logic [CNT_W-1:0]            divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotVld <= '0;
      slotReg <= '0;
    end else begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        slotVld[k] <= slotVld[k+1];
        slotReg[k] <= slotReg[k+1];
      end
      slotVld[DEPTH-1] <= 1'b0;
      slotReg[DEPTH-1] <= '0;
      if (strobe.push) begin
        slotVld[strobe.slot] <= 1'b1;
        slotReg[strobe.slot] <= strobe.dst;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      divCnt <= '0;
    else if (strobe.divStart)
      divCnt <= CNT_W'(DIV_BUSY - 1);
    else if (divCnt != '0)
      divCnt <= divCnt - 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gCmp
      assign hitA[g] = slotVld[g] && (slotReg[g] == srcA);
      assign hitB[g] = slotVld[g] && (slotReg[g] == srcB);
      assign hitD[g] = slotVld[g] && (slotReg[g] == dst);
    end
  endgenerate

  assign divBusy = (divCnt != '0);
  assign wbValid = slotVld[0];
  assign wbReg   = slotReg[0];
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import iil_pkg::*;
(
  input  logic             idValid,
  input  unit_e            unit,
  input  logic             dstWr,
  input  logic [REG_W-1:0] dst,
  input  logic             useA,
  input  logic             useB,
  input  logic [DEPTH-1:0] slotVld,
  input  logic [DEPTH-1:0] hitA,
  input  logic [DEPTH-1:0] hitB,
  input  logic [DEPTH-1:0] hitD,
  input  logic             divBusy,
  output logic             stall,
  output logic             issue,
  output strobe_t          strobe
);
  logic [IDX_W-1:0] lat;
  logic [DEPTH-1:0] beyond;
  logic [DEPTH-1:0] future;
  logic rawHit, wawHit, portHit, divHit;

  always_comb begin
    case (unit)
      UNIT_MEM: lat = IDX_W'(LAT_MEM);
      UNIT_ADD: lat = IDX_W'(LAT_ADD);
      UNIT_MUL: lat = IDX_W'(LAT_MUL);
      UNIT_DIV: lat = IDX_W'(LAT_DIV);
      default:  lat = IDX_W'(LAT_INT);
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gMask
      assign beyond[g] = (IDX_W'(g) > lat);
      assign future[g] = (g != 0);
    end
  endgenerate

  assign rawHit  = (useA && |(hitA & future)) || (useB && |(hitB & future));
  assign wawHit  = dstWr && |(hitD & beyond);
  assign portHit = dstWr && slotVld[lat];
  assign divHit  = (unit == UNIT_DIV) && divBusy;

  assign stall = idValid && (rawHit || wawHit || portHit || divHit);
  assign issue = idValid && !stall;

  always_comb begin
    strobe.push     = issue && dstWr;
    strobe.slot     = lat - 1'b1;
    strobe.dst      = dst;
    strobe.divStart = issue && (unit == UNIT_DIV);
  end
endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import iil_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             idValid,
  input  logic [2:0]       idUnit,
  input  logic             idDstWr,
  input  logic [REG_W-1:0] idDst,
  input  logic             idSrcAUse,
  input  logic [REG_W-1:0] idSrcA,
  input  logic             idSrcBUse,
  input  logic [REG_W-1:0] idSrcB,
  output logic             stall,
  output logic             issue,
  output logic             wbValid,
  output logic [REG_W-1:0] wbReg
);
  strobe_t          strobe;
  logic [DEPTH-1:0] slotVld, hitA, hitB, hitD;
  logic             divBusy;
  unit_e            unit;

  assign unit = unit_e'(idUnit);

  issue_ctrl u_ctrl (
    .idValid (idValid),
    .unit    (unit),
    .dstWr   (idDstWr),
    .dst     (idDst),
    .useA    (idSrcAUse),
    .useB    (idSrcBUse),
    .slotVld (slotVld),
    .hitA    (hitA),
    .hitB    (hitB),
    .hitD    (hitD),
    .divBusy (divBusy),
    .stall   (stall),
    .issue   (issue),
    .strobe  (strobe)
  );

  issue_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcA    (idSrcA),
    .srcB    (idSrcB),
    .dst     (idDst),
    .slotVld (slotVld),
    .hitA    (hitA),
    .hitB    (hitB),
    .hitD    (hitD),
    .divBusy (divBusy),
    .wbValid (wbValid),
    .wbReg   (wbReg)
  );
endmodule

// File: rtl/fp_issue_interlock_chk.sv
module fp_issue_interlock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       idValid,
  input logic [2:0] idUnit,
  input logic       idDstWr,
  input logic [4:0] idDst,
  input logic       stall,
  input logic       issue,
  input logic       wbValid,
  input logic [4:0] wbReg
);
  logic [4:0] divGap;

  always_ff @(posedge clk) begin
    if (!rstN)
      divGap <= 5'd31;
    else if (issue && idUnit == 3'd4)
      divGap <= 5'd1;
    else if (divGap != 5'd31)
      divGap <= divGap + 5'd1;
  end

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (issue && idUnit == 3'd4) |-> (divGap >= 5'd25)); // R6

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |-> (!stall && !issue)); // R7

  AST_INT_WB: assert property (@(posedge clk) disable iff (!rstN)
    (issue && idDstWr && idUnit == 3'd0) |-> ##2 (wbValid && wbReg == $past(idDst, 2))); // R2

  AST_ADD_WB: assert property (@(posedge clk) disable iff (!rstN)
    (issue && idDstWr && idUnit == 3'd2) |-> ##5 (wbValid && wbReg == $past(idDst, 5))); // R2

  AST_ISSUE_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> idValid); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !wbValid); // R1
endmodule

bind fp_issue_interlock fp_issue_interlock_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .idValid (idValid),
  .idUnit  (idUnit),
  .idDstWr (idDstWr),
  .idDst   (idDst),
  .stall   (stall),
  .issue   (issue),
  .wbValid (wbValid),
  .wbReg   (wbReg)
);

// File: tb/sim_fp_issue_interlock.sv
`timescale 1ns/1ps
module sim_fp_issue_interlock;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idValid = 1'b0;
  logic [2:0] idUnit = 3'd0;
  logic idDstWr = 1'b0;
  logic [4:0] idDst = '0;
  logic idSrcAUse = 1'b0;
  logic [4:0] idSrcA = '0;
  logic idSrcBUse = 1'b0;
  logic [4:0] idSrcB = '0;
  logic stall, issue, wbValid;
  logic [4:0] wbReg;

  always #4 clk = ~clk;

  fp_issue_interlock u0 (.*);

  int nCmp = 0, nBad = 0, cyc = 0, lastDiv = -1000;
  int recWb [64];
  logic [4:0] recDst [64];
  bit recVld [64];
  bit timedOut = 0;

  function automatic int latOf(input logic [2:0] u);
    case (u)
      3'd2: return 5;
      3'd3: return 8;
      3'd4: return 26;
      default: return 2;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic doCycle(output bit issued);
    bit raw, waw, port, divb, expV;
    int L;
    logic [4:0] expR;
    string tag;
    L = latOf(idUnit);
    raw = 0; waw = 0; port = 0; expV = 0; expR = '0;
    for (int i = 0; i < 64; i++) begin
      if (recVld[i] && recWb[i] < cyc) recVld[i] = 0;
      if (recVld[i]) begin
        if (recWb[i] > cyc && ((idSrcAUse && recDst[i] == idSrcA) || (idSrcBUse && recDst[i] == idSrcB))) raw = 1;
        if (idDstWr && recWb[i] > cyc + L && recDst[i] == idDst) waw = 1;
        if (idDstWr && recWb[i] == cyc + L) port = 1;
        if (recWb[i] == cyc) begin expV = 1; expR = recDst[i]; end
      end
    end
    divb = (idUnit == 3'd4) && (cyc < lastDiv + 25);
    #2;
    tag = raw ? "R5" : waw ? "R4" : port ? "R3" : divb ? "R6" : "R7";
    check(tag, int'(stall), int'(idValid && (raw || waw || port || divb)));
    check("R7_issue", int'(issue), int'(idValid && !stall));
    check("R2_wbValid", int'(wbValid), int'(expV));
    if (expV) check("R8_wbReg", int'(wbReg), int'(expR));
    issued = idValid && !(raw || waw || port || divb);
    @(posedge clk);
    if (issued) begin
      if (idDstWr) begin
        for (int i = 0; i < 64; i++)
          if (!recVld[i]) begin
            recVld[i] = 1; recWb[i] = cyc + L; recDst[i] = idDst; break;
          end
      end
      if (idUnit == 3'd4) lastDiv = cyc;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic runOp(input logic [2:0] u, input logic [4:0] d, input bit dw,
                       input logic [4:0] a, input bit ua, input logic [4:0] b, input bit ub,
                       output int stalls);
    bit got;
    stalls = 0;
    idValid = 1; idUnit = u; idDst = d; idDstWr = dw;
    idSrcA = a; idSrcAUse = ua; idSrcB = b; idSrcBUse = ub;
    got = 0;
    while (!got && !timedOut) begin
      doCycle(got);
      if (!got) stalls++;
    end
    idValid = 0;
  endtask

  task automatic idle(input int n);
    bit g;
    idValid = 0;
    for (int i = 0; i < n; i++) doCycle(g);
  endtask

  initial begin
    #(8 * 150000);
    timedOut = 1;
  end

  initial begin
    int s;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) recVld[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #2;
    check("R1_wbValid", int'(wbValid), 0);
    check("R1_stall", int'(stall), 0);
    @(negedge clk);

    // R6: back-to-back divides to different registers
    runOp(3'd4, 5'd1, 1, 5'd9, 1, 5'd10, 1, s);
    runOp(3'd4, 5'd2, 1, 5'd9, 1, 5'd10, 1, s);
    check("R6_div_stalls", s, 24);
    idle(30);

    // R3: multiply, five independent ints, then an int landing on the multiply's slot
    runOp(3'd3, 5'd1, 1, 5'd9, 1, 5'd10, 0, s);
    for (int i = 0; i < 5; i++) runOp(3'd0, 5'(i + 2), 1, 5'd11, 0, 5'd12, 0, s);
    runOp(3'd0, 5'd7, 1, 5'd11, 0, 5'd12, 0, s);
    check("R3_port_stalls", s, 1);
    idle(12);

    // R4: an add to r1 may not overtake a divide to r1
    runOp(3'd4, 5'd1, 1, 5'd9, 0, 5'd10, 0, s);
    runOp(3'd2, 5'd1, 1, 5'd9, 0, 5'd10, 0, s);
    check("R4_waw_stalls", s, 21);
    idle(30);

    // R5: reader of an add result waits until its writeback cycle
    runOp(3'd2, 5'd3, 1, 5'd9, 0, 5'd10, 0, s);
    runOp(3'd0, 5'd4, 1, 5'd3, 1, 5'd10, 0, s);
    check("R5_raw_stalls", s, 4);
    idle(10);

    // R6: a busy divider does not hold back an integer op
    runOp(3'd4, 5'd5, 1, 5'd9, 0, 5'd10, 0, s);
    runOp(3'd0, 5'd6, 1, 5'd11, 1, 5'd12, 1, s);
    check("R6_int_during_div", s, 0);
    idle(30);

    // R2: a store-like op without a write produces no writeback
    runOp(3'd1, 5'd7, 0, 5'd9, 1, 5'd10, 1, s);
    idle(4);

    // random streams over a small register pool
    for (int n = 0; n < 600 && !timedOut; n++) begin
      int r;
      logic [2:0] u;
      r = $urandom_range(0, 9);
      u = (r < 3) ? 3'd0 : (r < 5) ? 3'd1 : (r < 7) ? 3'd2 : (r < 9) ? 3'd3 : 3'd4;
      runOp(u, 5'($urandom_range(0, 7)), bit'($urandom_range(0, 5) != 0),
            5'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
            5'($urandom_range(0, 7)), bit'($urandom_range(0, 1)), s);
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(30);

    if (timedOut) begin
      nCmp++; nBad++;
      $display("FAIL watchdog cycle %0d actual 1 expected 0", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule